// File: doc/BRIEF.md
# Debounced Push-Button Single-Pulse Generator

This block converts the level of a bouncing mechanical push-button into a strobe that is high for exactly one cycle of the processor clock for each distinct press. A processor can use that strobe to resume from an active wait, so each press advances it by exactly one step no matter how long a finger stays on the button.

The work is split across two clocks. A slow sampling clock of a few hundred hertz shifts the raw button into a short qualification chain. The button counts as pressed only while every stage of that chain holds 1, so a press is accepted only after a window of consecutive high samples (about 15 ms at 190 Hz with the default depth). The qualified level then enters a three-deep history register on the processor clock. The strobe fires when the two newest history entries are high and the oldest is low. The design assumes no fixed ratio between the two clocks. It needs only that the sampling clock period covers at least two processor cycles. One synchronous reset, sampled by each clock, clears both chains.

Top module: `btn_pulse_gen`

## Requirements
- R1: A press is qualified only when the last QUAL_STAGES (default 3) samples of `btn_raw`, taken on rising edges of `clk_smp`, are all 1. A press that spans exactly three sampling edges yields one strobe.
- R2: A high interval on `btn_raw` that covers fewer than QUAL_STAGES sampling edges never produces a strobe.
- R3: `press_pulse` is never high for two processor cycles in a row.
- R4: `press_pulse` is high in a processor cycle exactly when the qualified level was 1 at the two most recent `clk_cpu` edges and 0 at the edge before them. The history bit order is newest = bit 0, and the match value is 3'b011.
- R5: A button held for any length of time yields exactly one strobe.
- R6: Two presses separated by a release of at least QUAL_STAGES sampling periods yield two strobes.
- R7: While `rst` is high, sampled on both clocks, all stages clear and `press_pulse` is 0. After release, no strobe appears until QUAL_STAGES fresh samples of 1 have been taken, even with the button held through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | Processor clock; drives the history register and the strobe |
| clk_smp | input | 1 | Slow sampling clock for qualification |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| btn_raw | input | 1 | Raw, bouncing button level |
| press_pulse | output | 1 | One-cycle strobe per qualified press |

## Verification
The interesting coincidence is a release that ends the qualification window in the same processor cycle that the strobe is emitted. This happens with a press that covers exactly three sampling edges, because the qualified level then stays high for only two processor cycles. The bench provokes it with directed three-sample presses and with many random short high and low segments. A cycle-level model built from the requirements judges every processor cycle, and a separate width monitor checks that no strobe is stretched or doubled.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
   // processor-side history depth; the match needs newest two plus one older
   localparam int HIST_DEPTH = 3;
   typedef logic [HIST_DEPTH-1:0] hist_t;
   // bit 0 newest: two fresh highs after one low
   localparam hist_t PRESS_MATCH = 3'b011;
endpackage

// File: rtl/bpg_qualifier.sv
module bpg_qualifier #(
   parameter int STAGES = 3
) (
   input  logic clk_smp,
   input  logic rst,
   input  logic btn_raw,
   output logic level_ok
);
   logic [STAGES-1:0] smp_q;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("bpg_qualifier: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_smp) begin
            if (rst) smp_q <= '0;
            else     smp_q <= btn_raw;
         end
         assign level_ok = smp_q[0];
      end else begin : g_chain
         always_ff @(posedge clk_smp) begin
            if (rst) smp_q <= '0;
            else     smp_q <= {smp_q[STAGES-2:0], btn_raw};
         end
         assign level_ok = &smp_q;
      end
   endgenerate
endmodule

// File: rtl/bpg_history.sv
module bpg_history
   import bpg_pkg::*;
(
   input  logic  clk_cpu,
   input  logic  rst,
   input  logic  level_in,
   output hist_t hist
);
   always_ff @(posedge clk_cpu) begin
      if (rst) hist <= '0;
      else     hist <= {hist[HIST_DEPTH-2:0], level_in};
   end
endmodule

// File: rtl/bpg_edge_match.sv
module bpg_edge_match
   import bpg_pkg::*;
(
   input  hist_t hist,
   output logic  hit
);
   assign hit = (hist == PRESS_MATCH);
endmodule

// File: rtl/btn_pulse_gen.sv
module btn_pulse_gen #(
   parameter int QUAL_STAGES = 3
) (
   input  logic clk_cpu,
   input  logic clk_smp,
   input  logic rst,
   input  logic btn_raw,
   output logic press_pulse
);
   import bpg_pkg::*;

   logic  qual_level;
   hist_t hist_q;

   bpg_qualifier #(.STAGES(QUAL_STAGES)) u_qual (
      .clk_smp (clk_smp),
      .rst     (rst),
      .btn_raw (btn_raw),
      .level_ok(qual_level)
   );

   bpg_history u_hist (
      .clk_cpu (clk_cpu),
      .rst     (rst),
      .level_in(qual_level),
      .hist    (hist_q)
   );

   bpg_edge_match u_match (
      .hist(hist_q),
      .hit (press_pulse)
   );
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
   parameter int QUAL_STAGES = 3
) (
   input logic clk_cpu,
   input logic clk_smp,
   input logic rst,
   input logic btn_raw,
   input logic qual_level,
   input logic press_pulse
);
   logic rst_d;
   always_ff @(posedge clk_cpu) rst_d <= rst;

   // R7: the cycle after a reset edge shows no strobe
   always @(posedge clk_cpu) begin
      if (rst_d) a_r7_quiet_after_reset: assert (!press_pulse);
   end

   // R3: strobe lasts a single processor cycle
   a_r3_single_cycle: assert property (@(posedge clk_cpu) disable iff (rst)
      press_pulse |=> !press_pulse);

   // R4: strobe needs the qualified level at the two latest processor edges
   a_r4_level_history: assert property (@(posedge clk_cpu) disable iff (rst)
      press_pulse |-> ($past(qual_level) && $past(qual_level, 2)));

   generate
      if (QUAL_STAGES == 3) begin : g_q3
         // R1: qualified level implies three consecutive high samples
         a_r1_three_samples: assert property (@(posedge clk_smp) disable iff (rst)
            qual_level |-> ($past(btn_raw) && $past(btn_raw, 2) && $past(btn_raw, 3)));
      end
   endgenerate

   // R2: a fresh qualification needs the newest sample high
   a_r2_rise_needs_button: assert property (@(posedge clk_smp) disable iff (rst)
      $rose(qual_level) |-> $past(btn_raw));
endmodule

bind btn_pulse_gen bpg_checker #(.QUAL_STAGES(QUAL_STAGES)) u_chk (
   .clk_cpu    (clk_cpu),
   .clk_smp    (clk_smp),
   .rst        (rst),
   .btn_raw    (btn_raw),
   .qual_level (qual_level),
   .press_pulse(press_pulse)
);

// File: tb/btn_pulse_gen_bench.sv
`timescale 1ns/1ps
module btn_pulse_gen_bench;
   logic clk_cpu = 1'b0;
   logic clk_smp = 1'b0;
   logic rst = 1'b1;
   logic btn = 1'b1;
   logic press_pulse;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;
   bit prev_pulse = 1'b0;

   btn_pulse_gen u_btn_pulse_gen (
      .clk_cpu    (clk_cpu),
      .clk_smp    (clk_smp),
      .rst        (rst),
      .btn_raw    (btn),
      .press_pulse(press_pulse)
   );

   // 50 MHz processor clock; sampling clock two times slower, offset 5 ns
   always #10 clk_cpu = ~clk_cpu;
   initial begin
      #5;
      forever #20 clk_smp = ~clk_smp;
   end

   // requirement model: three samples, three-deep history, match 3'b011
   logic [2:0] m_smp = 3'b000;
   logic [2:0] m_hist = 3'b000;
   always @(posedge clk_smp) m_smp <= rst ? 3'b000 : {m_smp[1:0], btn};
   always @(posedge clk_cpu) m_hist <= rst ? 3'b000 : {m_hist[1:0], &m_smp};

   function automatic bit exp_pulse(input logic [2:0] h);
      return h == 3'b011;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every cycle: R4 against model, R3 width monitor
   always @(negedge clk_cpu) begin
      if (!done) begin
         check(press_pulse === exp_pulse(m_hist), "R4 cycle match",
               int'(press_pulse), int'(exp_pulse(m_hist)));
         if (prev_pulse)
            check(press_pulse === 1'b0, "R3 one-cycle width", int'(press_pulse), 0);
         if (press_pulse === 1'b1) pulses++;
         prev_pulse = (press_pulse === 1'b1);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_cpu);
   endtask

   initial begin
      int base;
      void'($urandom(32'd1234));
      // R7: button held through reset
      cyc(8);
      check(press_pulse === 1'b0, "R7 low during reset", int'(press_pulse), 0);
      rst = 1'b0;
      base = pulses;
      cyc(5);
      check(pulses - base == 0, "R7 no early strobe after reset", pulses - base, 0);
      cyc(40);
      check(pulses - base == 1, "R5 held through reset gives one", pulses - base, 1);
      btn = 1'b0;
      cyc(20);

      // R5: long hold
      base = pulses;
      btn = 1'b1; cyc(60); btn = 1'b0; cyc(20);
      check(pulses - base == 1, "R5 long hold single strobe", pulses - base, 1);

      // R2: high for two sampling edges (4 processor cycles)
      base = pulses;
      btn = 1'b1; cyc(4); btn = 1'b0; cyc(20);
      check(pulses - base == 0, "R2 two-sample bounce", pulses - base, 0);
      // R2: one-cycle glitch
      base = pulses;
      btn = 1'b1; cyc(1); btn = 1'b0; cyc(20);
      check(pulses - base == 0, "R2 glitch", pulses - base, 0);
      // R2: bounce train of short highs
      base = pulses;
      for (int i = 0; i < 6; i++) begin
         btn = 1'b1; cyc(3); btn = 1'b0; cyc(2);
      end
      cyc(20);
      check(pulses - base == 0, "R2 bounce train", pulses - base, 0);

      // R1: exactly three sampling edges (6 processor cycles)
      base = pulses;
      btn = 1'b1; cyc(6); btn = 1'b0; cyc(20);
      check(pulses - base == 1, "R1 three-sample press", pulses - base, 1);

      // R6: two separate presses
      base = pulses;
      btn = 1'b1; cyc(20); btn = 1'b0; cyc(10);
      btn = 1'b1; cyc(20); btn = 1'b0; cyc(20);
      check(pulses - base == 2, "R6 two presses", pulses - base, 2);

      // R7: reset mid-hold clears state
      btn = 1'b1; cyc(20);
      rst = 1'b1; cyc(6);
      check(press_pulse === 1'b0, "R7 reset mid-hold", int'(press_pulse), 0);
      rst = 1'b0;
      base = pulses;
      cyc(4);
      check(pulses - base == 0, "R7 quiet window", pulses - base, 0);
      btn = 1'b0; cyc(20);

      // random segments, judged per cycle by the model (R4, R3)
      for (int i = 0; i < 400; i++) begin
         btn = 1'($urandom_range(1, 0));
         cyc(int'($urandom_range(14, 1)));
      end
      btn = 1'b0;
      cyc(20);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_cpu);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule